// File: doc/BRIEF.md
# Sparse Space Bus Address Translator

This block turns a processor access into sparse address space into a bus request for PCI-style memory or I/O. In sparse space, the processor address carries the transfer size and the byte lane in low address bits, above the naturally aligned bytes. The block decodes these bits into a 32-bit bus address and four active-low byte enables. It works out which of three sparse memory windows or the I/O window was hit. It keeps only the address bits that window allows. For the largest memory window, it fills in the top bus address bits from a small host-address-extension register that software programs.

Requests come in through a valid/ready handshake and leave through a second valid/ready handshake. Only one request can be inside the block at a time. A request is rejected if its size/lane pair is illegal or if its address lies outside every sparse window. A rejected request still produces one response, with an error flag set. That response carries no byte enables, so it must not start a bus cycle. Accepting a request takes one clock edge, and its response is valid from the next cycle. While a response waits, the input side is not ready, so the block takes at most one request every two cycles.

Top module: `sparse_xlate`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. The extension register is 000, so a request in memory window 1 gets bus address bits 31:29 = 000.
- R2: `in_addr[4:3]` is the size code: 0 = byte, 1 = word, 2 = three bytes, 3 = four bytes. `in_addr[6:5]` is the lane offset. Each legal pair gives these active-low enables:
  - byte at offsets 0, 1, 2, 3: 1110, 1101, 1011, 0111;
  - word at offset 0: 1100, word at offset 2: 0011;
  - three bytes at offset 0: 1000, three bytes at offset 1: 0001;
  - four bytes at offset 2: 0000.
- R3: Every other size/offset pair is an error response: `out_err`=1, `out_be_n`=1111, `out_addr`=0, `out_is_io`=0. This includes a word at offset 1.
- R4: The window is chosen from the 40-bit address:
  - memory window 1: 0x80_0000_0000 to 0x83_FFFF_FFFF;
  - memory window 2: 0x84_0000_0000 to 0x84_FFFF_FFFF;
  - memory window 3: 0x85_0000_0000 to 0x85_7FFF_FFFF;
  - I/O window: 0x85_8000_0000 to 0x85_FFFF_FFFF, which sets `out_is_io`=1.
  Any other address gives the error response of R3.
- R5: The bus address is `in_addr` shifted right by 5 and masked to 29, 27, 26 or 26 bits, for memory windows 1, 2, 3 and I/O in that order. In window 1, bits 31:29 hold the extension register. In the other windows, the bits above the mask are 0.
- R6: Bus address bits 1:0 equal the lane offset for byte and word transfers. They are 00 for three-byte and four-byte transfers.
- R7: A write on `hae_we` loads `hae_wdata` at that clock edge. A request accepted at the same edge still uses the old value. Requests accepted later use the new one.
- R8: At most one request is inside the block. `in_ready` is 0 while a response is valid. A response is valid from the cycle after acceptance and stays valid and stable until `out_ready` is seen high.
- R9: An error response uses the same handshake as a good one. It holds `in_ready` low until it is taken, and then the block accepts the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hae_we | input | 1 | Write strobe for the extension register |
| hae_wdata | input | 3 | New extension register value |
| in_valid | input | 1 | Processor request present |
| in_ready | output | 1 | Block can take a request |
| in_addr | input | 40 | Processor sparse-space address |
| out_valid | output | 1 | Response present |
| out_ready | input | 1 | Downstream takes the response |
| out_addr | output | 32 | Bus address |
| out_be_n | output | 4 | Active-low byte enables |
| out_is_io | output | 1 | Request targets I/O space |
| out_err | output | 1 | Unsupported request, no bus cycle |

## Verification
The bench builds the block with its default parameters: a 40-bit processor address, a 32-bit bus, a 3-bit extension field, and mask widths of 29, 27, 26 and 26. With these values every window edge can be reached with ordinary 40-bit addresses. This covers the last line of window 1, the first of window 2, the split between window 3 and I/O, and the addresses just below and just above sparse space. Address bits set above each mask show the masking at work. Stalls on `out_ready`, including one held over an error response, exercise the one-outstanding rule. A write to the extension register in the same cycle as an acceptance exercises the ordering rule.

// File: rtl/sst_pkg.sv
package sst_pkg;
  // which sparse window a request falls in
  typedef enum logic [2:0] {
    RG_NONE = 3'd0,
    RG_MEM1 = 3'd1,
    RG_MEM2 = 3'd2,
    RG_MEM3 = 3'd3,
    RG_IO   = 3'd4
  } region_e;

  // size code carried in address bits 4:3
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_TRI   = 2'd2,
    SZ_QUAD4 = 2'd3
  } size_e;

  localparam int LANES     = 4;
  localparam int SIZE_LSB  = 3;
  localparam int LANE_LSB  = 5;
  localparam int FIELD_TOP = LANE_LSB + 2;

  typedef struct packed {
    logic             ok;
    logic [LANES-1:0] be_n;
    logic [1:0]       lo;
  } lane_res_t;
endpackage

// File: rtl/sst_hae_reg.sv
module sst_hae_reg #(
  parameter int HAE_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [HAE_W-1:0] wdata,
  output logic [HAE_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/sst_lane_decode.sv
module sst_lane_decode
  import sst_pkg::*;
(
  input  size_e      size,
  input  logic [1:0] offs,
  output lane_res_t  res
);
  always_comb begin
    res.ok   = 1'b0;
    res.be_n = '1;
    res.lo   = 2'b00;
    unique case (size)
      SZ_BYTE: begin
        res.ok   = 1'b1;
        res.be_n = ~(LANES'(1) << offs);
        res.lo   = offs;
      end
      SZ_WORD: begin
        if (offs == 2'd0) begin
          res.ok = 1'b1; res.be_n = 4'b1100; res.lo = 2'd0;
        end else if (offs == 2'd2) begin
          res.ok = 1'b1; res.be_n = 4'b0011; res.lo = 2'd2;
        end
      end
      SZ_TRI: begin
        if (offs == 2'd0) begin
          res.ok = 1'b1; res.be_n = 4'b1000;
        end else if (offs == 2'd1) begin
          res.ok = 1'b1; res.be_n = 4'b0001;
        end
      end
      SZ_QUAD4: begin
        if (offs == 2'd2) begin
          res.ok = 1'b1; res.be_n = 4'b0000;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sst_region_decode.sv
module sst_region_decode
  import sst_pkg::*;
#(
  parameter int              ADDR_W    = 40,
  parameter int              BUS_W     = 32,
  parameter int              HAE_W     = 3,
  parameter int              M1_W      = 29,
  parameter int              M2_W      = 27,
  parameter int              M3_W      = 26,
  parameter int              IO_W      = 26,
  parameter logic [ADDR_W-1:0] M1_BASE = 40'h80_0000_0000,
  parameter logic [ADDR_W-1:0] M2_BASE = 40'h84_0000_0000,
  parameter logic [ADDR_W-1:0] M3_BASE = 40'h85_0000_0000,
  parameter logic [ADDR_W-1:0] IO_BASE = 40'h85_8000_0000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [HAE_W-1:0]  hae,
  output region_e           region,
  output logic [BUS_W-1:0]  bus_hi
);
  localparam int          W_NUM = 4;
  localparam int          WIDS [W_NUM] = '{M1_W, M2_W, M3_W, IO_W};
  localparam logic [ADDR_W-1:0] BASES [W_NUM] = '{M1_BASE, M2_BASE, M3_BASE, IO_BASE};

  logic [W_NUM-1:0]  hit;
  logic [BUS_W-1:0]  masked [W_NUM];
  logic [BUS_W-1:0]  field;
  logic              unused_low;

  assign field      = addr[LANE_LSB +: BUS_W];
  assign unused_low = ^addr[LANE_LSB-1:0];

  for (genvar k = 0; k < W_NUM; k++) begin : g_win
    localparam int SPAN = WIDS[k] + LANE_LSB;
    localparam logic [BUS_W-1:0] MASK = BUS_W'((64'd1 << WIDS[k]) - 64'd1);
    assign hit[k]    = (addr[ADDR_W-1:SPAN] == BASES[k][ADDR_W-1:SPAN]);
    assign masked[k] = field & MASK;
  end

  always_comb begin
    region = RG_NONE;
    bus_hi = '0;
    if (hit[0]) begin
      region = RG_MEM1;
      bus_hi = masked[0] | (BUS_W'(hae) << M1_W);
    end else if (hit[1]) begin
      region = RG_MEM2;
      bus_hi = masked[1];
    end else if (hit[2]) begin
      region = RG_MEM3;
      bus_hi = masked[2];
    end else if (hit[3]) begin
      region = RG_IO;
      bus_hi = masked[3];
    end
  end
endmodule

// File: rtl/sparse_xlate.sv
module sparse_xlate
  import sst_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int BUS_W  = 32,
  parameter int HAE_W  = 3,
  parameter int M1_W   = 29,
  parameter int M2_W   = 27,
  parameter int M3_W   = 26,
  parameter int IO_W   = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hae_we,
  input  logic [HAE_W-1:0]  hae_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BUS_W-1:0]  out_addr,
  output logic [LANES-1:0]  out_be_n,
  output logic              out_is_io,
  output logic              out_err
);
  logic [HAE_W-1:0] hae_q;
  region_e          region;
  logic [BUS_W-1:0] bus_hi;
  lane_res_t        lane;
  logic             reject;
  logic [BUS_W-1:0] bus_addr;
  logic             pend;
  logic             take;

  sst_hae_reg #(.HAE_W(HAE_W)) u_hae (
    .clk(clk), .rst(rst), .we(hae_we), .wdata(hae_wdata), .q(hae_q)
  );

  sst_region_decode #(
    .ADDR_W(ADDR_W), .BUS_W(BUS_W), .HAE_W(HAE_W),
    .M1_W(M1_W), .M2_W(M2_W), .M3_W(M3_W), .IO_W(IO_W)
  ) u_region (
    .addr(in_addr), .hae(hae_q), .region(region), .bus_hi(bus_hi)
  );

  sst_lane_decode u_lane (
    .size(size_e'(in_addr[SIZE_LSB +: 2])),
    .offs(in_addr[LANE_LSB +: 2]),
    .res (lane)
  );

  assign reject   = !lane.ok || (region == RG_NONE);
  assign bus_addr = {bus_hi[BUS_W-1:2], lane.lo};
  assign in_ready = !pend;
  assign take     = in_valid && in_ready;
  assign out_valid = pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      out_addr  <= '0;
      out_be_n  <= '1;
      out_is_io <= 1'b0;
      out_err   <= 1'b0;
    end else if (take) begin
      pend      <= 1'b1;
      out_err   <= reject;
      out_is_io <= !reject && (region == RG_IO);
      out_be_n  <= reject ? '1 : lane.be_n;
      out_addr  <= reject ? '0 : bus_addr;
    end else if (pend && out_ready) begin
      pend <= 1'b0;
    end
  end

  // checks next to the response register
  assert_reset_idle_R1: assert property (@(posedge clk) rst |=> !out_valid);

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) &&
      $stable(out_be_n) && $stable(out_err) && $stable(out_is_io));

  assert_accept_responds_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  assert_err_no_lanes_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_err |-> out_be_n == '1 && out_addr == '0);

  assert_good_has_lane_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_err |-> out_be_n != '1);

  assert_io_is_good_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_is_io |-> !out_err);

  assert_err_blocks_input_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_err |-> !in_ready);
endmodule

// File: tb/sparse_xlate_tb.sv
module sparse_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hae_we = 1'b0;
  logic [2:0]  hae_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [39:0] in_addr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_addr;
  logic [3:0]  out_be_n;
  logic        out_is_io;
  logic        out_err;

  int total = 0;
  int bad   = 0;
  bit bp    = 0;
  bit stall = 0;
  int cyc   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  sparse_xlate dut_i (
    .clk(clk), .rst(rst), .hae_we(hae_we), .hae_wdata(hae_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_be_n(out_be_n), .out_is_io(out_is_io), .out_err(out_err)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // reference: {err, io, be_n, addr}
  function automatic logic [37:0] ref_of(input logic [39:0] a, input logic [2:0] h);
    longint unsigned ua = a;
    longint unsigned q  = ua >> 5;
    int reg_n;
    int sz  = int'(a[4:3]);
    int off = int'(a[6:5]);
    logic [3:0] be;
    bit ok = 1;
    logic [31:0] ba;
    if (ua >= 40'h80_0000_0000 && ua < 40'h84_0000_0000) reg_n = 1;
    else if (ua >= 40'h84_0000_0000 && ua < 40'h85_0000_0000) reg_n = 2;
    else if (ua >= 40'h85_0000_0000 && ua < 40'h85_8000_0000) reg_n = 3;
    else if (ua >= 40'h85_8000_0000 && ua < 40'h86_0000_0000) reg_n = 4;
    else reg_n = 0;
    be = 4'b1111;
    if (sz == 0) be = ~(4'b0001 << off);
    else if (sz == 1 && off == 0) be = 4'b1100;
    else if (sz == 1 && off == 2) be = 4'b0011;
    else if (sz == 2 && off == 0) be = 4'b1000;
    else if (sz == 2 && off == 1) be = 4'b0001;
    else if (sz == 3 && off == 2) be = 4'b0000;
    else ok = 0;
    if (!ok || reg_n == 0) return {1'b1, 1'b0, 4'b1111, 32'h0};
    case (reg_n)
      1: ba = {h, 29'(q % (64'd1 << 29))};
      2: ba = 32'(q % (64'd1 << 27));
      default: ba = 32'(q % (64'd1 << 26));
    endcase
    if (sz >= 2) ba[1:0] = 2'b00;
    else ba[1:0] = 2'(off);
    return {1'b0, reg_n == 4, be, ba};
  endfunction

  // cycle model
  bit          m_pend = 0;
  logic [37:0] m_exp  = '0;
  logic [2:0]  m_hae  = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      m_pend <= 0; m_hae <= '0;
    end else begin
      if (in_valid && !m_pend) begin
        m_pend <= 1;
        m_exp  <= ref_of(in_addr, m_hae);
      end else if (m_pend && out_ready) m_pend <= 0;
      if (hae_we) m_hae <= hae_wdata;
    end
  end

  always @(negedge clk) begin
    out_ready <= stall ? 1'b0 : (bp ? (cyc % 3 == 0) : 1'b1);
    if (!rst && !done) begin
      chk("R8 valid", out_valid, m_pend);
      chk("R8 ready", in_ready, !m_pend);
      if (m_pend && out_valid) begin
        chk("R3 err", out_err, m_exp[37]);
        chk("R4 io", out_is_io, m_exp[36]);
        chk("R2 be_n", out_be_n, m_exp[35:32]);
        chk("R5 addr", out_addr, m_exp[31:0]);
      end
    end
  end

  function automatic logic [39:0] mk(input logic [39:0] base, input logic [31:0] q,
                                     input logic [1:0] sz);
    return base + (40'(q) << 5) + (40'(sz) << 3);
  endfunction

  task automatic send(input logic [39:0] a);
    bit acc;
    in_valid = 1'b1;
    in_addr  = a;
    forever begin
      acc = in_ready;
      @(negedge clk);
      if (acc) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic hae_write(input logic [2:0] v);
    hae_we = 1'b1; hae_wdata = v;
    @(negedge clk);
    hae_we = 1'b0;
  endtask

  task automatic drain();
    while (out_valid) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 in_ready", in_ready, 1);
    chk("R1 out_valid", out_valid, 0);
    send(mk(40'h80_0000_0000, 32'h0000_1234, 2'd0));
    chk("R1 hae zero", out_addr[31:29], 0);
    drain();

    // all size/offset pairs in window 1 (R2, R3)
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 4; o++) begin
        send(mk(40'h80_0000_0000, 32'h0ABC_0000 | 32'(o), 2'(s)));
        if (s == 2 && o == 1) chk("R6 tri low bits", out_addr[1:0], 0);
        if (s == 1 && o == 2) chk("R6 word low bits", out_addr[1:0], 2);
        drain();
      end

    // extension register and ordering (R5, R7)
    hae_write(3'd5);
    send(mk(40'h80_0000_0000, 32'h1FFF_FFF0, 2'd0));
    chk("R5 hae upper", out_addr[31:29], 5);
    drain();
    hae_wdata = 3'd2; hae_we = 1'b1;
    send(mk(40'h81_0000_0000, 32'h0000_0040, 2'd1));
    hae_we = 1'b0;
    chk("R7 old value used", out_addr[31:29], 5);
    drain();
    send(mk(40'h80_0000_0000, 32'h0000_0041, 2'd0));
    chk("R7 new value used", out_addr[31:29], 2);
    drain();

    // window edges and masking (R4, R5)
    send(40'h83_FFFF_FFE0 | 40'h40);
    send(40'h84_0000_0000);
    send(40'h84_FFFF_FFE0 | 40'h48);
    send(40'h85_0000_0000 | 40'h18 | 40'h40);
    send(40'h85_7FFF_FFE0);
    chk("R4 window3 not io", out_is_io, 0);
    send(40'h85_8000_0000 | 40'h20);
    chk("R4 io flag", out_is_io, 1);
    send(40'h85_FFFF_FFE0 | 40'h10);
    send(40'h7F_FFFF_FFE0);
    chk("R4 below sparse err", out_err, 1);
    send(40'h86_0000_0000);
    chk("R4 dense err", out_err, 1);
    drain();

    // error held under stall (R9)
    stall = 1;
    @(negedge clk);
    send(mk(40'h84_0000_0000, 32'h1, 2'd1));
    chk("R9 err flag", out_err, 1);
    repeat (3) @(negedge clk);
    chk("R9 held valid", out_valid, 1);
    chk("R9 input blocked", in_ready, 0);
    stall = 0;
    drain();
    send(mk(40'h84_0000_0000, 32'h2, 2'd1));
    chk("R9 next accepted", out_err, 0);
    drain();

    // backpressure sweep (R8)
    bp = 1;
    for (int i = 0; i < 60; i++)
      send(mk((i % 2) ? 40'h85_8000_0000 : 40'h80_0000_0000,
              32'(i * 32'h0101_0117), 2'(i % 4)));
    bp = 0;
    drain();
    repeat (2) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule